// File: doc/BRIEF.md
# Multi-Format Audio Serial Transmitter

This block is the master end of a stereo serial audio link. From the system clock it divides down a bit clock and a channel-select clock. It shifts out one left and one right sample per frame, most significant bit first, in two's complement. Samples arrive as a left/right pair on a parallel valid/ready port. The block takes one pair at the start of every frame and needs no FIFO.

A single bit-selection stage serves three alignment formats. In the delayed (I2S) format, the channel-select line moves one bit period ahead of the word. In MSB-justified format, the first bit of the word is sent in the bit period where the line changes. In LSB-justified format, the word is pushed to the end of its slot. The word length and the slot length (bit periods per channel) are run-time inputs and stay static while the block is out of reset. The following must hold: 1 <= word length <= slot length, 2 <= slot length, and word length <= DATA_W.

Top module: `aud_ser_tx`

## Requirements
- R1: `sck_o` is a square wave with a period of 2*(div_i+1) system clocks. A bit period runs from one falling edge of `sck_o` to the next.
- R2: `sdo_o` and `lrck_o` change only in the system clock cycle where `sck_o` falls, so a receiver can latch both on the rising edge.
- R3: In formats 1 and 2, `lrck_o` is 0 for every bit of the left slot and 1 for every bit of the right slot. The left slot is the first slot of each frame.
- R4: In format code 0 (I2S), `lrck_o` takes the value of the next slot one bit period before that slot starts. The MSB of the word is sent in the first bit period of the slot, which is one period after the transition. Bits after the LSB are 0.
- R5: In format code 1 (MSB-justified), the MSB is sent in the bit period where `lrck_o` changes. The remaining word_len_i-1 bits follow. All later bits of the slot are 0.
- R6: In format code 2 (LSB-justified), the LSB is the last bit of the slot. The word occupies the final word_len_i bit periods, and all earlier bits of the slot are 0.
- R7: The word sent for a channel is bits [word_len_i-1:0] of `in_left_i` or `in_right_i`. Bits at and above word_len_i are ignored.
- R8: `in_ready_o` goes high for exactly one system clock per frame, in the cycle before the first bit of the frame starts. A pair offered with `in_valid_i` in that cycle is the pair sent in that frame.
- R9: If `in_valid_i` is low while `in_ready_o` is high, the whole frame is sent as zeros. `underrun_o` is then high for one system clock, in the cycle the frame's first bit starts.
- R10: While `rst_ni` is low: `sck_o`=0, `lrck_o`=1, `sdo_o`=0, `in_ready_o`=0 and `underrun_o`=0. The first falling edge of `sck_o` after reset starts a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fmt_i | input | 2 | Format code: 0 I2S, 1 MSB-justified, 2 LSB-justified |
| word_len_i | input | WL_W (5) | Word length in bits |
| slot_len_i | input | SL_W (6) | Bit periods per channel slot |
| div_i | input | DIV_W (8) | Half-period of the bit clock, in system clocks, minus one |
| in_valid_i | input | 1 | Sample pair offered |
| in_ready_o | output | 1 | Pair taken this cycle (frame boundary) |
| in_left_i | input | DATA_W (24) | Left sample, right-aligned |
| in_right_i | input | DATA_W (24) | Right sample, right-aligned |
| sck_o | output | 1 | Bit clock |
| lrck_o | output | 1 | Channel select, 0 = left |
| sdo_o | output | 1 | Serial data |
| underrun_o | output | 1 | One-cycle pulse: frame started without a sample |

## Verification
The sample handshake and the first bit of a frame fall in the same system clock edge. The pair accepted on that edge drives `sdo_o` directly for the bit that starts there, and in MSB-justified and I2S formats that bit is already the MSB. The bench provokes this in three ways: with `in_valid_i` held high, with it held low, and with it raised between the first and second frame boundaries. It judges every bit period against a model of the selected format, and it also compares the counts of ready, handshake and underrun pulses with the number of frames started.

// File: rtl/aud_tx_pkg.sv
package aud_tx_pkg;
  typedef enum logic [1:0] {
    FMT_I2S  = 2'd0,
    FMT_MSBJ = 2'd1,
    FMT_LSBJ = 2'd2,
    FMT_RSV  = 2'd3
  } fmt_e;
endpackage

// File: rtl/aud_clk_gen.sv
module aud_clk_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  output logic             sck_o,
  output logic             fall_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             sck_q;
  logic             tick;

  assign tick   = (cnt_q >= div_i);
  assign fall_o = tick & sck_q;
  assign sck_o  = sck_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sck_q <= 1'b0;
    end else if (tick) begin
      cnt_q <= '0;
      sck_q <= ~sck_q;
    end else begin
      cnt_q <= cnt_q + DIV_W'(1);
    end
  end

  // R1
  sck_half_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sck_q) |-> $past(cnt_q == div_i));
endmodule

// File: rtl/aud_bit_sel.sv
module aud_bit_sel
  import aud_tx_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int SLOT_W = 32,
  localparam int WL_W = $clog2(DATA_W + 1),
  localparam int SL_W = $clog2(SLOT_W + 1)
) (
  input  logic [1:0]        fmt_i,
  input  logic [WL_W-1:0]   word_len_i,
  input  logic [SL_W-1:0]   slot_len_i,
  input  logic [SL_W-1:0]   rel_i,
  input  logic [DATA_W-1:0] word_i,
  output logic              bit_o
);
  localparam int CW = ((SL_W > WL_W) ? SL_W : WL_W) + 1;

  logic [CW-1:0]     rel, wl, sl, idx;
  logic              hit;
  logic [DATA_W-1:0] sh;

  always_comb begin
    rel = CW'(rel_i);
    wl  = CW'(word_len_i);
    sl  = CW'(slot_len_i);
    hit = 1'b0;
    idx = '0;
    if (fmt_i == FMT_LSBJ) begin
      // word occupies the tail of the slot
      if (rel + wl >= sl) begin
        hit = 1'b1;
        idx = sl - CW'(1) - rel;
      end
    end else if (rel < wl) begin
      hit = 1'b1;
      idx = wl - CW'(1) - rel;
    end
    sh    = word_i >> idx;
    bit_o = hit & sh[0];
  end
endmodule

// File: rtl/aud_frame_ctrl.sv
module aud_frame_ctrl
  import aud_tx_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int SLOT_W = 32,
  localparam int SL_W = $clog2(SLOT_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        fmt_i,
  input  logic [SL_W-1:0]   slot_len_i,
  input  logic              fall_i,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] in_left_i,
  input  logic [DATA_W-1:0] in_right_i,
  output logic              in_ready_o,
  output logic              underrun_o,
  output logic              lrck_o,
  output logic [SL_W-1:0]   rel_o,
  output logic [DATA_W-1:0] word_o
);
  localparam int FP_W = $clog2(2 * SLOT_W);
  localparam int CW   = FP_W + 2;

  logic [FP_W-1:0]   pos_q;
  logic              lrck_q, underrun_q;
  logic [DATA_W-1:0] left_q, right_q, left_nxt, right_nxt;
  logic [CW-1:0]     pos_w, slot_w, frame_w, nxt_w, ahd_w;
  logic              wrap, ch_nxt, ch_ahd, load, lrck_nxt;

  always_comb begin
    pos_w   = CW'(pos_q);
    slot_w  = CW'(slot_len_i);
    frame_w = slot_w << 1;
    wrap    = (pos_w + CW'(1)) >= frame_w;
    nxt_w   = wrap ? '0 : pos_w + CW'(1);
    ahd_w   = ((nxt_w + CW'(1)) >= frame_w) ? '0 : nxt_w + CW'(1);
    ch_nxt  = nxt_w >= slot_w;
    ch_ahd  = ahd_w >= slot_w;
    // I2S: select line leads the slot by one bit
    lrck_nxt = (fmt_i == FMT_I2S) ? ch_ahd : ch_nxt;
    rel_o    = SL_W'(ch_nxt ? nxt_w - slot_w : nxt_w);
  end

  assign load       = fall_i & wrap;
  assign in_ready_o = load;
  assign left_nxt   = load ? (in_valid_i ? in_left_i  : '0) : left_q;
  assign right_nxt  = load ? (in_valid_i ? in_right_i : '0) : right_q;
  assign word_o     = ch_nxt ? right_nxt : left_nxt;
  assign lrck_o     = lrck_q;
  assign underrun_o = underrun_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q      <= '1;
      lrck_q     <= 1'b1;
      left_q     <= '0;
      right_q    <= '0;
      underrun_q <= 1'b0;
    end else begin
      left_q     <= left_nxt;
      right_q    <= right_nxt;
      underrun_q <= load & ~in_valid_i;
      if (fall_i) begin
        pos_q  <= FP_W'(nxt_w);
        lrck_q <= lrck_nxt;
      end
    end
  end

  // R8
  ready_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o |=> !in_ready_o);

  // R9
  underrun_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underrun_q |-> $past(in_ready_o && !in_valid_i));

  // R2
  lrck_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(lrck_q) |-> $past(fall_i));
endmodule

// File: rtl/aud_ser_tx.sv
module aud_ser_tx
  import aud_tx_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int SLOT_W = 32,
  parameter int DIV_W  = 8,
  localparam int WL_W = $clog2(DATA_W + 1),
  localparam int SL_W = $clog2(SLOT_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        fmt_i,
  input  logic [WL_W-1:0]   word_len_i,
  input  logic [SL_W-1:0]   slot_len_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [DATA_W-1:0] in_left_i,
  input  logic [DATA_W-1:0] in_right_i,
  output logic              sck_o,
  output logic              lrck_o,
  output logic              sdo_o,
  output logic              underrun_o
);
  logic              fall, bit_nxt, sdo_q;
  logic [SL_W-1:0]   rel_nxt;
  logic [DATA_W-1:0] word_nxt;

  aud_clk_gen #(.DIV_W(DIV_W)) i_clk_gen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .div_i  (div_i),
    .sck_o  (sck_o),
    .fall_o (fall)
  );

  aud_frame_ctrl #(.DATA_W(DATA_W), .SLOT_W(SLOT_W)) i_frame_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fmt_i      (fmt_i),
    .slot_len_i (slot_len_i),
    .fall_i     (fall),
    .in_valid_i (in_valid_i),
    .in_left_i  (in_left_i),
    .in_right_i (in_right_i),
    .in_ready_o (in_ready_o),
    .underrun_o (underrun_o),
    .lrck_o     (lrck_o),
    .rel_o      (rel_nxt),
    .word_o     (word_nxt)
  );

  aud_bit_sel #(.DATA_W(DATA_W), .SLOT_W(SLOT_W)) i_bit_sel (
    .fmt_i      (fmt_i),
    .word_len_i (word_len_i),
    .slot_len_i (slot_len_i),
    .rel_i      (rel_nxt),
    .word_i     (word_nxt),
    .bit_o      (bit_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   sdo_q <= 1'b0;
    else if (fall) sdo_q <= bit_nxt;
  end

  assign sdo_o = sdo_q;

  // R2
  sdo_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sdo_q) |-> $fell(sck_o));
endmodule

// File: tb/test_aud_ser_tx.sv
`timescale 1ns/1ps
module test_aud_ser_tx;
  typedef struct packed {
    logic [1:0]  fmt;
    logic [4:0]  wl;
    logic [5:0]  sl;
    logic [7:0]  div;
    logic [23:0] l;
    logic [23:0] r;
  } vec_t;

  localparam int NV = 6;
  // rows 2, 4, 5 carry junk above the word (R7)
  localparam vec_t TBL [NV] = '{
    '{2'd0, 5'd16, 6'd16, 8'd1, 24'h00B3C5, 24'h004A1F},
    '{2'd1, 5'd24, 6'd32, 8'd0, 24'h80F00D, 24'h7E5A12},
    '{2'd2, 5'd20, 6'd32, 8'd2, 24'hFABCDE, 24'h912345},
    '{2'd0, 5'd24, 6'd32, 8'd0, 24'hC00003, 24'h3FFFFC},
    '{2'd2, 5'd16, 6'd16, 8'd1, 24'hAA8001, 24'h557FFE},
    '{2'd1, 5'd8,  6'd16, 8'd3, 24'hFFFF81, 24'h00007E}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  fmt_i = '0;
  logic [4:0]  word_len_i = 5'd16;
  logic [5:0]  slot_len_i = 6'd16;
  logic [7:0]  div_i = '0;
  logic        in_valid_i = 1'b0;
  logic [23:0] in_left_i = '0, in_right_i = '0;
  logic        in_ready_o, sck_o, lrck_o, sdo_o, underrun_o;

  int vec_n = 0;
  int err_n = 0;

  always #2 clk_i = ~clk_i;

  aud_ser_tx i_aud_ser_tx (
    .clk_i, .rst_ni, .fmt_i, .word_len_i, .slot_len_i, .div_i,
    .in_valid_i, .in_ready_o, .in_left_i, .in_right_i,
    .sck_o, .lrck_o, .sdo_o, .underrun_o
  );

  task automatic check(input logic ok, input string what, input int act, input int exp);
    vec_n++;
    if (!ok) begin
      err_n++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  function automatic logic exp_bit(input logic [1:0] fmt, input int w, input int s,
                                   input int pos, input logic [23:0] word_l,
                                   input logic [23:0] word_r);
    int r;
    logic [23:0] wd;
    r  = (pos >= s) ? pos - s : pos;
    wd = (pos >= s) ? word_r : word_l;
    if (fmt == 2'd2) return (r >= s - w) ? wd[s-1-r] : 1'b0;
    return (r < w) ? wd[w-1-r] : 1'b0;
  endfunction

  // hole: 0 samples always valid, 1 first frame missing, 2 all frames missing
  task automatic run_case(input vec_t v, input int hole);
    int s, nb, bitk, cyc, last, ur_n, rdy_n, hs_n, pos, frm;
    logic prev_sck, cur_sdo, cur_lrck, bad2, e_sdo, e_lrck, zero;
    string req;
    fmt_i = v.fmt; word_len_i = v.wl; slot_len_i = v.sl; div_i = v.div;
    in_left_i = v.l; in_right_i = v.r;
    in_valid_i = (hole == 0);
    rst_ni = 1'b0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    // R10
    check(!sck_o && lrck_o && !sdo_o && !in_ready_o && !underrun_o,
          "R10 reset state", {sck_o, lrck_o, sdo_o, in_ready_o, underrun_o}, 5'b01000);
    rst_ni = 1'b1;
    s = int'(v.sl); nb = 4 * s;
    bitk = 0; cyc = 0; last = 0; ur_n = 0; rdy_n = 0; hs_n = 0;
    prev_sck = 1'b0; cur_sdo = 1'b0; cur_lrck = 1'b1; bad2 = 1'b0;
    req = (v.fmt == 2'd0) ? "R4" : (v.fmt == 2'd1) ? "R5/R3/R7" : "R6/R3/R7";
    while (bitk < nb) begin
      @(negedge clk_i);
      cyc++;
      if (in_ready_o) rdy_n++;
      if (in_ready_o && in_valid_i) hs_n++;
      if (underrun_o) ur_n++;
      if (prev_sck && !sck_o) begin
        pos = bitk % (2 * s);
        frm = bitk / (2 * s);
        zero = (hole == 2) || (hole == 1 && frm == 0);
        e_sdo = zero ? 1'b0 : exp_bit(v.fmt, int'(v.wl), s, pos, v.l, v.r);
        e_lrck = (v.fmt == 2'd0) ? (((pos + 1) % (2 * s)) >= s) : (pos >= s);
        check(sdo_o == e_sdo && lrck_o == e_lrck,
              $sformatf("%s%s bit %0d {lrck,sdo}", req, zero ? "/R9" : "", bitk),
              {lrck_o, sdo_o}, {e_lrck, e_sdo});
        // R1
        if (bitk > 0)
          check(cyc - last == 2 * (int'(v.div) + 1), "R1 bit period", cyc - last,
                2 * (int'(v.div) + 1));
        last = cyc;
        cur_sdo = sdo_o; cur_lrck = lrck_o;
        if (hole == 1 && bitk == 0) in_valid_i = 1'b1;
        bitk++;
      end else if (sdo_o != cur_sdo || lrck_o != cur_lrck) begin
        bad2 = 1'b1;
      end
      prev_sck = sck_o;
    end
    // R2
    check(!bad2, "R2 change away from falling sck", bad2, 0);
    // R8
    check(rdy_n == 2, "R8 ready pulses", rdy_n, 2);
    check(hs_n == 2 - hole, "R8 handshakes", hs_n, 2 - hole);
    // R9
    check(ur_n == hole, "R9 underrun pulses", ur_n, hole);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    err_n++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vec_n, err_n);
    $finish;
  end

  initial begin
    for (int i = 0; i < NV; i++) run_case(TBL[i], 0);
    // R9: no sample at any frame boundary
    run_case(TBL[1], 2);
    // R9/R8: sample appears between first and second frame boundary
    run_case(TBL[0], 1);
    run_case(TBL[2], 1);
    $display("== %0d vectors applied, %0d miscompares ==", vec_n, err_n);
    $finish;
  end
endmodule